// File: doc/BRIEF.md
# Link-Register Return-Address Stack

This block stands behind one architectural 32-bit general-purpose register, the link register, and turns it into a small hardware return-address stack. The register file treats it like any other register. A read returns the entry on top of the stack and marks a pop. A write captures a value to be pushed. Neither changes the stack right away. Pending operations are applied only when the instruction commit strobe fires, and the abort strobe throws them away.

At commit the pending pop is applied before the pending push. An instruction that both reads and writes the link register therefore replaces the top entry, even when the stack is full. A pop from an empty stack is an underflow. A push onto a stack that still holds 8 entries after the pop is an overflow. Either fault is reported in the commit cycle with error code 2, and the faulting instruction leaves the stack exactly as it was.

A side-band debug port shows the top entry without popping it, and shows a fixed marker when the stack is empty. The current depth and the full and empty flags are also brought out.

Top module: `lr_call_stack`

## Requirements
- R1: After reset the stack is empty: depth_o = 0, empty_o = 1, full_o = 0, and fault_o, underflow_o and overflow_o are 0.
- R2: rd_data_o shows the top entry, or 0 when the stack is empty. A read (rd_en_i) marks a pop that takes effect only at commit. Any number of reads during one instruction, including a read in the commit cycle itself, cause exactly one pop.
- R3: A write (wr_en_i) holds its value as pending, and that value is pushed at commit. If several writes occur in one instruction, the last one wins. A write in the commit cycle itself takes precedence over any earlier write.
- R4: At commit the pop is applied before the push. A read together with a write on a full stack replaces the top entry, depth stays at 8, and no fault is raised.
- R5: A push at commit, with no pop, while the stack holds 8 entries raises fault_o and overflow_o combinationally in the commit cycle, and leaves the depth and the contents unchanged.
- R6: A pop at commit while the stack is empty raises fault_o and underflow_o combinationally in the commit cycle, and leaves the stack unchanged. This holds even when a push is also pending, and in that case overflow_o stays 0.
- R7: abort_i discards the pending pop and the pending push without touching the stack. When abort_i and commit_i are high in the same cycle, the abort wins.
- R8: dbg_data_o shows the top entry and never pops. It shows 32'hCAFEF00D when the stack is empty.
- R9: depth_o reports the entry count, from 0 to 8. empty_o is 1 exactly when the depth is 0, and full_o is 1 exactly when the depth is 8.
- R10: err_code_o is 2 while fault_o is high and 0 otherwise. A commit with no pending operation changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_en_i | input | 1 | Register-file read of the link register |
| rd_data_o | output | 32 | Top entry (0 when empty) |
| wr_en_i | input | 1 | Register-file write of the link register |
| wr_data_i | input | 32 | Write data |
| commit_i | input | 1 | Instruction commit strobe |
| abort_i | input | 1 | Instruction abort strobe |
| dbg_data_o | output | 32 | Non-popping view of the top entry |
| depth_o | output | 4 | Current entry count |
| empty_o | output | 1 | Stack is empty |
| full_o | output | 1 | Stack holds 8 entries |
| fault_o | output | 1 | Fault in this commit cycle |
| underflow_o | output | 1 | The fault is an underflow |
| overflow_o | output | 1 | The fault is an overflow |
| err_code_o | output | 8 | Error code: 2 on a fault, else 0 |

## Verification
Some properties are checked on every cycle by the assertions:
- the storage never pops while empty and never pushes past full;
- a faulting or aborted commit moves neither pointer, and the depth stays the same on the next cycle;
- a read together with a write never overflows;
- the error code follows the fault flag.

Other behaviours only show up at the ports through the bench's scenarios:
- several reads collapse into one pop;
- the last write value is the one pushed;
- an abort truly forgets the pending work;
- the debug port shows the empty marker.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int unsigned LRS_DATA_W = 32;
  localparam int unsigned LRS_DEPTH  = 8;
  localparam int unsigned LRS_ERR_W  = 8;

  localparam logic [LRS_ERR_W-1:0] ERR_NONE       = 8'd0;
  localparam logic [LRS_ERR_W-1:0] ERR_CALL_STACK = 8'd2;

  localparam logic [LRS_DATA_W-1:0] DBG_EMPTY_MARK = 32'hCAFE_F00D;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'b00,
    FLT_UNDER = 2'b01,
    FLT_OVER  = 2'b10
  } fault_kind_e;
endpackage

// File: rtl/lrs_pending.sv
module lrs_pending #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              clear_i,
  output logic              pop_eff_o,
  output logic              push_eff_o,
  output logic [DATA_W-1:0] push_val_o
);
  logic              pop_pend_q;
  logic              push_pend_q;
  logic [DATA_W-1:0] push_val_q;

  // A read or write in the strobe cycle itself counts for that instruction.
  assign pop_eff_o  = pop_pend_q | rd_en_i;
  assign push_eff_o = push_pend_q | wr_en_i;
  assign push_val_o = wr_en_i ? wr_data_i : push_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pop_pend_q  <= 1'b0;
      push_pend_q <= 1'b0;
      push_val_q  <= '0;
    end else if (clear_i) begin
      pop_pend_q  <= 1'b0;
      push_pend_q <= 1'b0;
      push_val_q  <= '0;
    end else begin
      if (rd_en_i) pop_pend_q <= 1'b1;
      if (wr_en_i) begin
        push_pend_q <= 1'b1;
        push_val_q  <= wr_data_i;
      end
    end
  end

  // R2: a read outside a strobe stays pending into the next cycle
  a_r2_pop_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && !clear_i |=> pop_eff_o);

  // R3: the last write value is what is offered for the push
  a_r3_last_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !clear_i |=> push_eff_o && (rd_en_i || 1'b1) &&
      (wr_en_i || push_val_o == $past(wr_data_i)));

  // R7: a strobe leaves nothing pending
  a_r7_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (pop_eff_o == rd_en_i) && (push_eff_o == wr_en_i));
endmodule

// File: rtl/lrs_commit_ctrl.sv
module lrs_commit_ctrl
  import lrs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 commit_i,
  input  logic                 abort_i,
  input  logic                 pop_eff_i,
  input  logic                 push_eff_i,
  input  logic                 empty_i,
  input  logic                 full_i,
  output logic                 do_pop_o,
  output logic                 do_push_o,
  output logic                 clear_o,
  output fault_kind_e          fault_kind_o,
  output logic [LRS_ERR_W-1:0] err_code_o
);
  logic act;
  logic uflow;
  logic oflow;

  assign act     = commit_i & ~abort_i;
  assign clear_o = commit_i | abort_i;

  // Underflow takes priority: the instruction is cancelled before any push.
  assign uflow = act & pop_eff_i & empty_i;
  assign oflow = act & ~uflow & push_eff_i & ~pop_eff_i & full_i;

  always_comb begin
    fault_kind_o = FLT_NONE;
    if (uflow)      fault_kind_o = FLT_UNDER;
    else if (oflow) fault_kind_o = FLT_OVER;
  end

  assign do_pop_o   = act & pop_eff_i & ~uflow & ~oflow;
  assign do_push_o  = act & push_eff_i & ~uflow & ~oflow;
  assign err_code_o = (uflow | oflow) ? ERR_CALL_STACK : ERR_NONE;

  // R5 R6: a faulting commit moves nothing
  a_r5_fault_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_kind_o != FLT_NONE |-> !do_pop_o && !do_push_o);

  // R4: a read with a write on a non-empty stack never overflows
  a_r4_swap_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && pop_eff_i && push_eff_i && !empty_i |-> fault_kind_o != FLT_OVER);

  // R7: abort suppresses every effect
  a_r7_abort_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |-> !do_pop_o && !do_push_o && fault_kind_o == FLT_NONE);
endmodule

// File: rtl/lrs_storage.sv
module lrs_storage #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  output logic [DATA_W-1:0] top_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              empty_o,
  output logic              full_o
);
  logic [CNT_W-1:0]  depth_q;
  logic [CNT_W-1:0]  depth_d;
  logic [CNT_W-1:0]  wr_slot;
  logic [IDX_W-1:0]  top_idx;
  logic [DATA_W-1:0] mem_q [DEPTH];

  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == CNT_W'(DEPTH));
  assign depth_o = depth_q;
  assign top_idx = IDX_W'(depth_q - CNT_W'(1));
  assign top_o   = empty_o ? '0 : mem_q[top_idx];

  // Pop-then-push overwrites the current top slot.
  assign wr_slot = pop_i ? depth_q - CNT_W'(1) : depth_q;

  always_comb begin
    depth_d = depth_q;
    if (pop_i && !push_i)      depth_d = depth_q - CNT_W'(1);
    else if (push_i && !pop_i) depth_d = depth_q + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) depth_q <= '0;
    else         depth_q <= depth_d;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[g] <= '0;
      else if (push_i && wr_slot == CNT_W'(g))     mem_q[g] <= push_data_i;
    end
  end

  // R6: never pop an empty stack
  a_r6_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

  // R5: never push past the limit
  a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && !pop_i |-> !full_o);

  // R9: depth stays within bounds and flags are exclusive
  a_r9_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_q <= CNT_W'(DEPTH) && !(empty_o && full_o));

  // R4: a swap keeps the depth
  a_r4_swap_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && push_i |=> $stable(depth_q));

  // R3: a plain push lands on top
  a_r3_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |=> top_o == $past(push_data_i));
endmodule

// File: rtl/lr_call_stack.sv
module lr_call_stack
  import lrs_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rd_en_i,
  output logic [LRS_DATA_W-1:0] rd_data_o,
  input  logic                  wr_en_i,
  input  logic [LRS_DATA_W-1:0] wr_data_i,
  input  logic                  commit_i,
  input  logic                  abort_i,
  output logic [LRS_DATA_W-1:0] dbg_data_o,
  output logic [3:0]            depth_o,
  output logic                  empty_o,
  output logic                  full_o,
  output logic                  fault_o,
  output logic                  underflow_o,
  output logic                  overflow_o,
  output logic [LRS_ERR_W-1:0]  err_code_o
);
  logic                  pop_eff;
  logic                  push_eff;
  logic [LRS_DATA_W-1:0] push_val;
  logic                  do_pop;
  logic                  do_push;
  logic                  clear;
  fault_kind_e           fault_kind;
  logic [LRS_DATA_W-1:0] top;

  lrs_pending #(.DATA_W(LRS_DATA_W)) u_pending (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .clear_i    (clear),
    .pop_eff_o  (pop_eff),
    .push_eff_o (push_eff),
    .push_val_o (push_val)
  );

  lrs_commit_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .commit_i     (commit_i),
    .abort_i      (abort_i),
    .pop_eff_i    (pop_eff),
    .push_eff_i   (push_eff),
    .empty_i      (empty_o),
    .full_i       (full_o),
    .do_pop_o     (do_pop),
    .do_push_o    (do_push),
    .clear_o      (clear),
    .fault_kind_o (fault_kind),
    .err_code_o   (err_code_o)
  );

  lrs_storage #(.DEPTH(LRS_DEPTH), .DATA_W(LRS_DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (do_pop),
    .push_i      (do_push),
    .push_data_i (push_val),
    .top_o       (top),
    .depth_o     (depth_o),
    .empty_o     (empty_o),
    .full_o      (full_o)
  );

  assign rd_data_o   = top;
  assign dbg_data_o  = empty_o ? DBG_EMPTY_MARK : top;
  assign underflow_o = (fault_kind == FLT_UNDER);
  assign overflow_o  = (fault_kind == FLT_OVER);
  assign fault_o     = underflow_o | overflow_o;

  // R10: error code follows the fault flag
  a_r10_err_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o ? (err_code_o == ERR_CALL_STACK) : (err_code_o == ERR_NONE));

  // R5 R6: a fault leaves the depth and top unchanged
  a_r5_fault_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> $stable(depth_o) && $stable(dbg_data_o));

  // R8: debug view only differs from the read port when empty
  a_r8_dbg_view: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !empty_o |-> dbg_data_o == rd_data_o);
endmodule

// File: tb/lr_call_stack_test.sv
module lr_call_stack_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_en = 1'b0, wr_en = 1'b0, commit = 1'b0, abort_s = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data, dbg_data;
  logic [3:0]  depth;
  logic        empty, full, fault, uflow, oflow;
  logic [7:0]  err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int unsigned q[$];
  bit          m_pop = 1'b0, m_push = 1'b0;
  logic [31:0] m_val = '0;

  always #4 clk = ~clk;

  lr_call_stack uut (
    .clk_i(clk), .rst_ni(rst_n), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .commit_i(commit), .abort_i(abort_s),
    .dbg_data_o(dbg_data), .depth_o(depth), .empty_o(empty), .full_o(full),
    .fault_o(fault), .underflow_o(uflow), .overflow_o(oflow), .err_code_o(err)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cyc(input bit rd, input bit wr, input logic [31:0] wd,
                     input bit cm, input bit ab);
    bit pe, pu, act, e_uf, e_of;
    logic [31:0] v, top;
    int n;
    @(negedge clk);
    rd_en = rd; wr_en = wr; wr_data = wd; commit = cm; abort_s = ab;
    #1;
    n    = q.size();
    top  = (n == 0) ? 32'h0 : q[n-1];
    pe   = m_pop | rd;
    pu   = m_push | wr;
    v    = wr ? wd : m_val;
    act  = cm && !ab;
    e_uf = act && pe && n == 0;
    e_of = act && !e_uf && pu && !pe && n == 8;
    chk("R2", "rd_data", rd_data, top);
    chk("R8", "dbg_data", dbg_data, (n == 0) ? 32'hCAFEF00D : top);
    chk("R9", "depth", {28'h0, depth}, n);
    chk("R9", "empty", {31'h0, empty}, {31'h0, n == 0});
    chk("R9", "full", {31'h0, full}, {31'h0, n == 8});
    chk("R6", "underflow", {31'h0, uflow}, {31'h0, e_uf});
    chk("R5", "overflow", {31'h0, oflow}, {31'h0, e_of});
    chk("R10", "fault", {31'h0, fault}, {31'h0, e_uf | e_of});
    chk("R10", "err_code", {24'h0, err}, (e_uf | e_of) ? 32'd2 : 32'd0);
    @(posedge clk);
    if (act && !e_uf && !e_of) begin
      if (pe) void'(q.pop_back());
      if (pu) q.push_back(v);
    end
    if (cm || ab) begin
      m_pop = 1'b0; m_push = 1'b0; m_val = '0;
    end else begin
      if (rd) m_pop = 1'b1;
      if (wr) begin m_push = 1'b1; m_val = wd; end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk("R1", "depth", {28'h0, depth}, 0);
    chk("R1", "empty", {31'h0, empty}, 1);
    chk("R1", "full", {31'h0, full}, 0);
    chk("R1", "fault", {29'h0, fault, uflow, oflow}, 0);
    // R8 empty marker
    chk("R8", "dbg_empty", dbg_data, 32'hCAFEF00D);
    // R3 push in commit cycle, deferred push, last write wins
    cyc(0, 1, 32'h1000_00A0, 1, 0);
    cyc(0, 1, 32'h1000_00B0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 1, 32'h1000_00C0, 0, 0);
    cyc(0, 1, 32'h1000_00C4, 0, 0);
    cyc(0, 1, 32'h1000_00D0, 1, 0);
    // R2 two reads then commit: single pop
    cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 0, 1, 0);
    cyc(1, 0, 0, 1, 0);
    // R7 abort discards pending read and write
    cyc(1, 1, 32'hDEAD_0001, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 1, 0);          // R10 no-op commit
    cyc(1, 1, 32'hDEAD_0002, 1, 1); // R7 abort beats commit
    // fill to full
    for (int i = 1; i < 8; i++) cyc(0, 1, 32'h2000_0000 + i, 1, 0);
    // R5 overflow, pending write from earlier cycle
    cyc(0, 1, 32'hBAD0_0001, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 1, 32'hBAD0_0002, 1, 0);
    // R4 read plus write on full stack replaces top
    cyc(1, 1, 32'h3000_0001, 1, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 32'h3000_0002, 1, 0);
    // drain
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 1, 0);
    // R6 underflow, plain and with pending push
    cyc(1, 0, 0, 1, 0);
    cyc(1, 1, 32'h4000_0001, 1, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    // recovery after fault
    cyc(0, 1, 32'h5000_0001, 1, 0);
    cyc(0, 0, 0, 0, 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule